// File: doc/BRIEF.md
# Fuse Physical-to-Logical Map Decoder

This block turns a packed physical fuse image into a sparse logical configuration map. The physical image is held in a small byte memory inside the block, and the logical map in a second byte memory. Both memories have a registered read port with one cycle of latency. Software-side logic or a loader streams the image in through a valid/ready write port. A one-cycle start pulse then launches a decode pass.

A pass has two phases. First, every logical byte is set to 0xFF. Second, the block walks the usable part of the physical image one record at a time. Each record has a one- or two-byte header that names a block index and four active-low word enables. Each enabled word brings two data bytes, which are copied to the logical address that the block index and the slot select. When the pass ends, the block raises `done` for one cycle. `err` reports whether the pass aborted on a bounds violation. Afterwards the logical map can be read back one byte at a time.

The load port obeys one back-pressure rule: `ld_ready` is low for the whole pass. A byte is written only in a cycle where `ld_valid` and `ld_ready` are both high. Holding `ld_valid` high while the block is busy has no effect.

Top module: `fuse_map_decoder`

## Requirements
- R1: A `start` pulse while idle makes `busy` high on the next cycle, and `ld_ready` stays low for as long as `busy` is high.
- R2: Each pass first writes 0xFF to every logical byte; a logical byte that no record writes reads back as 0xFF after the pass.
- R3: The walk ends without error when the first header byte is 0xFF, or when its bits [4:0] equal 0x0F and the following byte is 0xFF.
- R4: If bits [4:0] of the first header byte differ from 0x0F, the header is that single byte: block index = bits [7:4], word enables = bits [3:0].
- R5: If bits [4:0] of the first header byte equal 0x0F, the header is two bytes: block index bits [2:0] = first byte [7:5], block index bits [6:3] = second byte [7:4], word enables = second byte [3:0].
- R6: Word-enable bit i is active low: a 0 means two data bytes follow for slot i, a 1 skips slot i; slots are taken in order 0, 1, 2, 3.
- R7: The data bytes of slot i go to logical addresses block×8 + 2i and the next address; a later record overwrites an earlier one at the same address.
- R8: Only physical bytes below PHYS_SIZE − PROT_SIZE are decoded; if that range is used up exactly at a record boundary, the pass ends without error.
- R9: If an enabled word's two physical bytes would reach PHYS_SIZE − PROT_SIZE or beyond, the pass aborts with `err` high.
- R10: If an enabled word's two logical bytes would reach LOG_SIZE or beyond, the pass aborts with `err` high.
- R11: `done` is high for exactly one cycle at the end of a pass, with `busy` low; `err` keeps its value until the next start.
- R12: While idle, `rd_data` shows the logical byte at `rd_addr` one cycle after the address is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Pulse that begins a decode pass (ignored while busy) |
| busy | output | 1 | High while a pass is running |
| done | output | 1 | One-cycle pulse at the end of a pass |
| err | output | 1 | Result of the last pass: 1 if it aborted on a bound |
| ld_valid | input | 1 | Physical image write request |
| ld_ready | output | 1 | Physical image write accepted when high |
| ld_addr | input | PA_W | Physical byte address to write |
| ld_data | input | 8 | Physical byte to write |
| rd_addr | input | LA_W | Logical byte address to read |
| rd_data | output | 8 | Logical byte, one cycle after `rd_addr` |

## Verification
The assertions assume that `start` is a pulse that reaches the block only between passes. The bench meets this by raising `start` for a single cycle and waiting for `done` before it does anything else. They also assume the physical image is written only while `ld_ready` is high; the bench loads the whole image before each pass. Readback addresses are applied only while the block is idle, so the read port and the fill phase never compete for meaning.

// File: rtl/fmd_pkg.sv
package fmd_pkg;
  localparam int IDX_W = 12;

  typedef enum logic [3:0] {
    S_IDLE,
    S_FILL,
    S_H1_RD,
    S_H2_RD,
    S_H2_WT,
    S_SLOT,
    S_W0,
    S_W1,
    S_W2
  } fmd_state_e;
endpackage

// File: rtl/fmd_byte_ram.sv
module fmd_byte_ram #(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/fmd_hdr_decode.sv
module fmd_hdr_decode (
  input  logic [7:0] first_b,
  input  logic [7:0] second_b,
  output logic       is_end,
  output logic       two_byte,
  output logic [6:0] blk,
  output logic [3:0] wen_n
);
  always_comb begin
    two_byte = (first_b[4:0] == 5'h0F);
    is_end   = (first_b == 8'hFF) || (two_byte && (second_b == 8'hFF));
    if (two_byte) begin
      blk   = {second_b[7:4], first_b[7:5]};
      wen_n = second_b[3:0];
    end else begin
      blk   = {3'b000, first_b[7:4]};
      wen_n = first_b[3:0];
    end
  end
endmodule

// File: rtl/fmd_walker.sv
module fmd_walker
  import fmd_pkg::*;
#(
  parameter int PHYS_SIZE = 64,
  parameter int PROT_SIZE = 8,
  parameter int LOG_SIZE  = 64,
  parameter int PA_W      = $clog2(PHYS_SIZE),
  parameter int LA_W      = $clog2(LOG_SIZE)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  output logic            busy,
  output logic            done,
  output logic            err,
  output logic [PA_W-1:0] phys_raddr,
  input  logic [7:0]      phys_rdata,
  output logic            log_we,
  output logic [LA_W-1:0] log_waddr,
  output logic [7:0]      log_wdata
);
  localparam logic [IDX_W-1:0] USABLE    = IDX_W'(PHYS_SIZE - PROT_SIZE);
  localparam logic [IDX_W-1:0] PHYS_LIM  = IDX_W'(PHYS_SIZE);
  localparam logic [IDX_W-1:0] LOG_LIM   = IDX_W'(LOG_SIZE);
  localparam logic [LA_W-1:0]  LAST_FILL = LA_W'(LOG_SIZE - 1);

  fmd_state_e       state;
  logic [IDX_W-1:0] phy_idx;
  logic [LA_W-1:0]  fill_cnt;
  logic [2:0]       slot;
  logic [6:0]       blk_q;
  logic [3:0]       wen_q;
  logic [7:0]       hdr1_q;
  logic             h2_oob;
  logic             done_q;
  logic             err_q;

  logic [7:0]       hdr2;
  logic             d_end;
  logic             d_two;
  logic [6:0]       d_blk;
  logic [3:0]       d_wen;
  logic [IDX_W-1:0] log_idx;
  logic [IDX_W-1:0] phy_nxt;

  assign hdr2    = h2_oob ? 8'hFF : phys_rdata;
  assign log_idx = IDX_W'({blk_q, 3'b000}) + IDX_W'({slot, 1'b0});
  assign phy_nxt = phy_idx + IDX_W'(1);

  fmd_hdr_decode hdr_i (
    .first_b  (hdr1_q),
    .second_b (hdr2),
    .is_end   (d_end),
    .two_byte (d_two),
    .blk      (d_blk),
    .wen_n    (d_wen)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      phy_idx  <= '0;
      fill_cnt <= '0;
      slot     <= '0;
      blk_q    <= '0;
      wen_q    <= '1;
      hdr1_q   <= 8'hFF;
      h2_oob   <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          err_q    <= 1'b0;
          fill_cnt <= '0;
          state    <= S_FILL;
        end
        S_FILL: begin
          fill_cnt <= fill_cnt + LA_W'(1);
          if (fill_cnt == LAST_FILL) begin
            phy_idx <= '0;
            state   <= S_H1_RD;
          end
        end
        S_H1_RD: begin
          if (phy_idx >= USABLE) begin
            done_q <= 1'b1;
            state  <= S_IDLE;
          end else begin
            state <= S_H2_RD;
          end
        end
        S_H2_RD: begin
          hdr1_q <= phys_rdata;
          h2_oob <= (phy_nxt >= PHYS_LIM);
          state  <= S_H2_WT;
        end
        S_H2_WT: begin
          if (d_end) begin
            done_q <= 1'b1;
            state  <= S_IDLE;
          end else begin
            blk_q   <= d_blk;
            wen_q   <= d_wen;
            phy_idx <= phy_idx + (d_two ? IDX_W'(2) : IDX_W'(1));
            slot    <= '0;
            state   <= S_SLOT;
          end
        end
        S_SLOT: begin
          if (slot[2]) begin
            state <= S_H1_RD;
          end else if (wen_q[slot[1:0]]) begin
            slot <= slot + 3'd1;
          end else if ((phy_idx + IDX_W'(2) > USABLE) ||
                       (log_idx + IDX_W'(2) > LOG_LIM)) begin
            err_q  <= 1'b1;
            done_q <= 1'b1;
            state  <= S_IDLE;
          end else begin
            state <= S_W0;
          end
        end
        S_W0: state <= S_W1;
        S_W1: state <= S_W2;
        S_W2: begin
          phy_idx <= phy_idx + IDX_W'(2);
          slot    <= slot + 3'd1;
          state   <= S_SLOT;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    phys_raddr = '0;
    log_we     = 1'b0;
    log_waddr  = '0;
    log_wdata  = 8'hFF;
    case (state)
      S_FILL: begin
        log_we    = 1'b1;
        log_waddr = fill_cnt;
      end
      S_H1_RD: phys_raddr = phy_idx[PA_W-1:0];
      S_H2_RD: if (phy_nxt < PHYS_LIM) phys_raddr = phy_nxt[PA_W-1:0];
      S_W0:    phys_raddr = phy_idx[PA_W-1:0];
      S_W1: begin
        phys_raddr = phy_nxt[PA_W-1:0];
        log_we     = 1'b1;
        log_waddr  = log_idx[LA_W-1:0];
        log_wdata  = phys_rdata;
      end
      S_W2: begin
        log_we    = 1'b1;
        log_waddr = log_idx[LA_W-1:0] + LA_W'(1);
        log_wdata = phys_rdata;
      end
      default: ;
    endcase
  end

  assign busy = (state != S_IDLE);
  assign done = done_q;
  assign err  = err_q;
endmodule

// File: rtl/fuse_map_decoder.sv
module fuse_map_decoder #(
  parameter int PHYS_SIZE = 64,
  parameter int PROT_SIZE = 8,
  parameter int LOG_SIZE  = 64,
  parameter int PA_W      = $clog2(PHYS_SIZE),
  parameter int LA_W      = $clog2(LOG_SIZE)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  output logic            busy,
  output logic            done,
  output logic            err,
  input  logic            ld_valid,
  output logic            ld_ready,
  input  logic [PA_W-1:0] ld_addr,
  input  logic [7:0]      ld_data,
  input  logic [LA_W-1:0] rd_addr,
  output logic [7:0]      rd_data
);
  logic [PA_W-1:0] phys_raddr;
  logic [7:0]      phys_rdata;
  logic            log_we;
  logic [LA_W-1:0] log_waddr;
  logic [7:0]      log_wdata;

  assign ld_ready = !busy;

  fmd_byte_ram #(.DEPTH(PHYS_SIZE), .AW(PA_W)) phys_ram_i (
    .clk   (clk),
    .we    (ld_valid && ld_ready),
    .waddr (ld_addr),
    .wdata (ld_data),
    .raddr (phys_raddr),
    .rdata (phys_rdata)
  );

  fmd_byte_ram #(.DEPTH(LOG_SIZE), .AW(LA_W)) log_ram_i (
    .clk   (clk),
    .we    (log_we),
    .waddr (log_waddr),
    .wdata (log_wdata),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  fmd_walker #(
    .PHYS_SIZE (PHYS_SIZE),
    .PROT_SIZE (PROT_SIZE),
    .LOG_SIZE  (LOG_SIZE),
    .PA_W      (PA_W),
    .LA_W      (LA_W)
  ) walker_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .busy       (busy),
    .done       (done),
    .err        (err),
    .phys_raddr (phys_raddr),
    .phys_rdata (phys_rdata),
    .log_we     (log_we),
    .log_waddr  (log_waddr),
    .log_wdata  (log_wdata)
  );
endmodule

// File: rtl/fmd_checker.sv
module fmd_checker (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic err
);
  AST_START_TO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy); // R1

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11

  AST_DONE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R11

  AST_ERR_RAISE_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> done); // R9

  AST_ERR_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(err)); // R11
endmodule

bind fuse_map_decoder fmd_checker chk_i (
  .clk   (clk),
  .rst_n (rst_n),
  .start (start),
  .busy  (busy),
  .done  (done),
  .err   (err)
);

// File: tb/fuse_map_decoder_tb_top.sv
module fuse_map_decoder_tb_top;
  localparam int PSZ = 64;
  localparam int PRT = 8;
  localparam int LSZ = 64;
  localparam int USE = PSZ - PRT;
  localparam int NV  = 8;

  localparam logic [95:0] VEC_IMG [NV] = '{
    96'h20_11_22_33_44_55_66_77_88_FF_FF_FF,
    96'h3A_A1_A2_B1_B2_FF_FF_FF_FF_FF_FF_FF,
    96'h2F_0E_C1_C2_FF_FF_FF_FF_FF_FF_FF_FF,
    96'h0F_FF_FF_FF_FF_FF_FF_FF_FF_FF_FF_FF,
    96'h8E_01_02_FF_FF_FF_FF_FF_FF_FF_FF_FF,
    96'h0E_01_02_0E_03_04_FF_FF_FF_FF_FF_FF,
    96'h5F_1C_D1_D2_D3_D4_FF_FF_FF_FF_FF_FF,
    96'hEF_0D_E1_E2_FF_FF_FF_FF_FF_FF_FF_FF
  };
  localparam bit VEC_ERR [NV] = '{0, 0, 0, 0, 1, 0, 0, 0};

  logic       clk = 0;
  logic       rst_n = 0;
  logic       start = 0;
  logic       busy, done, err;
  logic       ld_valid = 0;
  logic       ld_ready;
  logic [5:0] ld_addr = 0;
  logic [7:0] ld_data = 0;
  logic [5:0] rd_addr = 0;
  logic [7:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [7:0] pimg [PSZ];
  logic [7:0] emap [LSZ];
  bit         eerr;

  always #10 clk = ~clk;

  fuse_map_decoder #(.PHYS_SIZE(PSZ), .PROT_SIZE(PRT), .LOG_SIZE(LSZ)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .err(err),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_addr(ld_addr), .ld_data(ld_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model();
    int ph = 0;
    for (int a = 0; a < LSZ; a++) emap[a] = 8'hFF;
    eerr = 0;
    while (ph < USE) begin
      logic [7:0] h1, h2;
      int blk, wen;
      h1 = pimg[ph];
      h2 = (ph + 1 < PSZ) ? pimg[ph + 1] : 8'hFF;
      if (h1 == 8'hFF || (h1[4:0] == 5'h0F && h2 == 8'hFF)) break;
      if (h1[4:0] == 5'h0F) begin
        blk = {h2[7:4], h1[7:5]}; wen = h2[3:0]; ph += 2;
      end else begin
        blk = h1[7:4]; wen = h1[3:0]; ph += 1;
      end
      for (int i = 0; i < 4; i++) begin
        int li;
        if (wen[i]) continue;
        li = blk * 8 + i * 2;
        if (ph + 2 > USE || li + 2 > LSZ) begin eerr = 1; return; end
        emap[li] = pimg[ph]; emap[li + 1] = pimg[ph + 1];
        ph += 2;
      end
    end
  endtask

  task automatic load_img();
    for (int a = 0; a < PSZ; a++) begin
      @(negedge clk);
      ld_valid = 1; ld_addr = 6'(a); ld_data = pimg[a];
    end
    @(negedge clk);
    ld_valid = 0;
  endtask

  task automatic run_pass(input string tag);
    int wait_cnt = 0;
    @(negedge clk);
    start = 1;
    @(negedge clk);
    start = 0;
    chk({tag, " R1 busy after start"}, 32'(busy), 32'd1);
    chk({tag, " R1 ld_ready low while busy"}, 32'(ld_ready), 32'd0);
    while (!done && wait_cnt < 3000) begin
      @(negedge clk);
      wait_cnt++;
    end
    chk({tag, " R11 done seen"}, 32'(done), 32'd1);
    chk({tag, " R11 idle at done"}, 32'(busy), 32'd0);
    chk({tag, " R9 R10 err"}, 32'(err), 32'(eerr));
    @(negedge clk);
    chk({tag, " R11 done one cycle"}, 32'(done), 32'd0);
    chk({tag, " R11 err held"}, 32'(err), 32'(eerr));
  endtask

  task automatic check_map(input string tag);
    int bad = 0;
    int first_a = -1;
    logic [7:0] fa = 0, fe = 0;
    for (int a = 0; a < LSZ; a++) begin
      @(negedge clk);
      rd_addr = 6'(a);
      @(negedge clk);
      if (rd_data !== emap[a]) begin
        bad++;
        if (first_a < 0) begin first_a = a; fa = rd_data; fe = emap[a]; end
      end
    end
    checks++;
    if (bad != 0) begin
      errors++;
      $display("FAIL %s R2 R7 R12 map byte %0d actual=%0h expected=%0h",
               tag, first_a, fa, fe);
    end
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 reset done", 32'(done), 32'd0);
    chk("R11 reset err", 32'(err), 32'd0);
    chk("R1 reset busy", 32'(busy), 32'd0);
    chk("R1 reset ld_ready", 32'(ld_ready), 32'd1);
    rst_n = 1;

    // Table: R3 R4 R5 R6 R7 R10 patterns
    for (int v = 0; v < NV; v++) begin
      string tag;
      tag = $sformatf("vec%0d", v);
      for (int a = 0; a < PSZ; a++)
        pimg[a] = (a < 12) ? VEC_IMG[v][95 - 8 * a -: 8] : 8'hFF;
      model();
      chk({tag, " table err vs model"}, 32'(eerr), 32'(VEC_ERR[v]));
      load_img();
      run_pass(tag);
      check_map(tag);
    end

    // R8: usable range used up exactly at a record boundary, tail not decoded
    for (int r = 0; r < USE / 4; r++) begin
      pimg[4 * r]     = 8'h0F;
      pimg[4 * r + 1] = 8'h0E | 8'(((r % 8) >> 3) << 4);
      pimg[4 * r + 2] = 8'(r);
      pimg[4 * r + 3] = 8'(r + 8'h40);
      pimg[4 * r]     = 8'h0F | 8'((r % 8) << 5);
    end
    for (int a = USE; a < PSZ; a++) pimg[a] = 8'h0E;
    model();
    chk("R8 model no err", 32'(eerr), 32'd0);
    load_img();
    run_pass("R8 boundary");
    check_map("R8 boundary");

    // R9: last enabled word would run into protected tail
    for (int r = 0; r < 13; r++) begin
      pimg[4 * r]     = 8'h0F | 8'((r % 8) << 5);
      pimg[4 * r + 1] = 8'h0E;
      pimg[4 * r + 2] = 8'(r + 8'h80);
      pimg[4 * r + 3] = 8'(r + 8'h90);
    end
    pimg[52] = 8'h3E; pimg[53] = 8'h5A; pimg[54] = 8'h5B;
    pimg[55] = 8'h4E;
    for (int a = USE; a < PSZ; a++) pimg[a] = 8'h77;
    model();
    chk("R9 model err", 32'(eerr), 32'd1);
    load_img();
    run_pass("R9 overrun");
    check_map("R9 overrun");

    // R2: second pass refills with 0xFF (empty image)
    for (int a = 0; a < PSZ; a++) pimg[a] = 8'hFF;
    model();
    load_img();
    run_pass("R2 refill");
    check_map("R2 refill");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule